// File: doc/BRIEF.md
# Program Counter Transfer-of-Control Unit

This unit works out the next value of the 15-bit program counter of a small 8-bit controller. The decode logic raises `req` for one cycle, together with a mode code, the current PC, the immediate field of the instruction and the accumulator. Three modes need no memory and finish in one cycle: a short relative jump, an absolute jump inside the current 4k segment, and a long jump that replaces the whole PC. The PC has no pages. A relative jump carries into the upper bits.

Three modes read the program memory through a synchronous read port. The unit drives a one-cycle read strobe and holds the address until the memory answers with a valid strobe.
- **Indirect jump:** uses the accumulator as the low byte of a table address in the current 256-byte page. The byte fetched from there becomes the low byte of the target.
- **Indirect data:** fetches a table operand in the same way and leaves the PC unchanged.
- **Vector load:** fetches two adjacent bytes, upper byte first, and loads them into the PC.

A single-cycle `done` pulse marks every completed transfer.

Top module: `pc_xfer_unit`

## Requirements
- R1: After synchronous reset, `pc_next` is 0, `data_out` is 0, and `done` and `mem_rd` are low.
- R2: Mode 0 (relative) sets `pc_next` to `pc_in + 1 + sext(imm[5:0])` modulo 2^15, with carries into the upper bits. `done` is high in the cycle after the request.
- R3: In relative mode, offset 0 (the encoding reserved for +1) falls through to `pc_in + 1`. The most negative offset (−32) reaches `pc_in − 31`, and offset +31 reaches `pc_in + 32`.
- R4: Mode 1 (absolute) sets `pc_next` to `{pc_in[14:12], imm[11:0]}`, one cycle after the request.
- R5: Mode 2 (long) sets `pc_next` to `imm[14:0]`, one cycle after the request.
- R6: Mode 3 (indirect jump) reads address `{pc_in[14:8], acc}`. It then sets `pc_next` to `{pc_in[14:8], byte}`, where byte is the value returned.
- R7: Mode 4 (indirect data) reads address `{pc_in[14:8], acc}`. It puts the byte returned on `data_out` and sets `pc_next` to `pc_in`.
- R8: Mode 5 (vector) reads `imm` and then `imm + 1`, with the address wrapping modulo 2^15. It sets `pc_next` to `{upper[6:0], lower}`; bit 7 of the upper byte is dropped.
- R9: Each read is a one-cycle `mem_rd` pulse, and `mem_addr` is held until `mem_valid` arrives. For a memory mode, `done` pulses once, in the cycle after the final byte is valid.
- R10: Three kinds of input are ignored and produce no `done`, no read and no PC change:
  - a `req` while a read is outstanding;
  - a `mem_valid` while no read is outstanding;
  - mode codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle |
| mode | input | 3 | Transfer mode code (0 to 5, with 6 and 7 reserved) |
| pc_in | input | 15 | Current program counter |
| imm | input | 15 | Immediate field of the instruction |
| acc | input | 8 | Accumulator |
| mem_data | input | 8 | Program-memory read data |
| mem_valid | input | 1 | Read data valid |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 15 | Read address |
| pc_next | output | 15 | Computed next program counter |
| done | output | 1 | Transfer complete pulse |
| data_out | output | 8 | Table operand from an indirect data read |

## Verification
The hardest case to bring about is a second request, or a stray valid strobe, that arrives while a two-byte vector fetch is only part way through. The same applies to a vector address at the top of memory, where the second address wraps to zero.

The bench's memory responder gives each read its own latency. Some reads are answered in the very next cycle and some are held back for several cycles. The stimulus fires extra requests into those wait windows. It raises stray valid strobes only while the unit is idle, and it places vector addresses at 0x7FFF. Relative jumps are applied at PCs that sit on page and wrap boundaries.

// File: rtl/pc_xfer_pkg.sv
package pc_xfer_pkg;
  typedef enum logic [2:0] {
    XF_REL   = 3'd0,
    XF_ABS   = 3'd1,
    XF_LONG  = 3'd2,
    XF_IJMP  = 3'd3,
    XF_IDATA = 3'd4,
    XF_VEC   = 3'd5,
    XF_RSV6  = 3'd6,
    XF_RSV7  = 3'd7
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT_A = 2'd1,
    ST_WAIT_B = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pc_target_calc.sv
module pc_target_calc
  import pc_xfer_pkg::*;
#(
  parameter int PC_W  = 15,
  parameter int LO_W  = 8,
  parameter int ABS_W = 12,
  parameter int REL_W = 6
) (
  input  xfer_mode_e       mode,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [PC_W-1:0]  imm,
  input  logic [LO_W-1:0]  acc,
  output logic [PC_W-1:0]  direct_pc,
  output logic             is_direct,
  output logic             is_mem,
  output logic [PC_W-1:0]  rd_addr
);
  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  // Sign-extended relative displacement, counted from the following instruction.
  logic [PC_W-1:0] rel_off;
  assign rel_off = {{(PC_W-REL_W){imm[REL_W-1]}}, imm[REL_W-1:0]};

  always_comb begin
    direct_pc = pc_in;
    is_direct = 1'b0;
    is_mem    = 1'b0;
    rd_addr   = {pc_in[PC_W-1:LO_W], acc};
    case (mode)
      XF_REL:  begin direct_pc = pc_in + ONE + rel_off; is_direct = 1'b1; end
      XF_ABS:  begin direct_pc = {pc_in[PC_W-1:ABS_W], imm[ABS_W-1:0]}; is_direct = 1'b1; end
      XF_LONG: begin direct_pc = imm; is_direct = 1'b1; end
      XF_IJMP, XF_IDATA: is_mem = 1'b1;
      XF_VEC:  begin is_mem = 1'b1; rd_addr = imm; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_fetch_seq.sv
module pc_fetch_seq
  import pc_xfer_pkg::*;
#(
  parameter int PC_W = 15,
  parameter int LO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  xfer_mode_e       mode,
  input  logic             is_direct,
  input  logic             is_mem,
  input  logic [PC_W-1:0]  direct_pc,
  input  logic [PC_W-1:0]  rd_addr,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [LO_W-1:0]  mem_data,
  input  logic             mem_valid,
  output logic [PC_W-1:0]  pc_next,
  output logic             done,
  output logic             mem_rd,
  output logic [PC_W-1:0]  mem_addr,
  output logic [LO_W-1:0]  data_out,
  output logic             busy
);
  localparam int HI_W = PC_W - LO_W;
  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  seq_state_e       state;
  xfer_mode_e       mode_q;
  logic [PC_W-1:0]  hold_pc;
  logic [HI_W-1:0]  vec_hi;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= XF_REL;
      hold_pc  <= '0;
      vec_hi   <= '0;
      pc_next  <= '0;
      done     <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      data_out <= '0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req && is_direct) begin
            pc_next <= direct_pc;
            done    <= 1'b1;
          end else if (req && is_mem) begin
            mem_addr <= rd_addr;
            mem_rd   <= 1'b1;
            hold_pc  <= pc_in;
            mode_q   <= mode;
            state    <= ST_WAIT_A;
          end
        end
        ST_WAIT_A: begin
          if (mem_valid) begin
            if (mode_q == XF_VEC) begin
              vec_hi   <= mem_data[HI_W-1:0];
              mem_addr <= mem_addr + ONE;
              mem_rd   <= 1'b1;
              state    <= ST_WAIT_B;
            end else begin
              if (mode_q == XF_IDATA) begin
                data_out <= mem_data;
                pc_next  <= hold_pc;
              end else begin
                pc_next  <= {hold_pc[PC_W-1:LO_W], mem_data};
              end
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_WAIT_B: begin
          if (mem_valid) begin
            pc_next <= {vec_hi, mem_data};
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pc_xfer_unit.sv
module pc_xfer_unit
  import pc_xfer_pkg::*;
#(
  parameter int PC_W  = 15,
  parameter int LO_W  = 8,
  parameter int ABS_W = 12,
  parameter int REL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [2:0]       mode,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [PC_W-1:0]  imm,
  input  logic [LO_W-1:0]  acc,
  input  logic [LO_W-1:0]  mem_data,
  input  logic             mem_valid,
  output logic             mem_rd,
  output logic [PC_W-1:0]  mem_addr,
  output logic [PC_W-1:0]  pc_next,
  output logic             done,
  output logic [LO_W-1:0]  data_out
);
  xfer_mode_e       mode_e;
  logic [PC_W-1:0]  direct_pc;
  logic [PC_W-1:0]  rd_addr;
  logic             is_direct;
  logic             is_mem;
  logic             busy;

  assign mode_e = xfer_mode_e'(mode);

  pc_target_calc #(.PC_W(PC_W), .LO_W(LO_W), .ABS_W(ABS_W), .REL_W(REL_W)) u_calc (
    .mode(mode_e), .pc_in(pc_in), .imm(imm), .acc(acc),
    .direct_pc(direct_pc), .is_direct(is_direct), .is_mem(is_mem), .rd_addr(rd_addr)
  );

  pc_fetch_seq #(.PC_W(PC_W), .LO_W(LO_W)) u_seq (
    .clk(clk), .rst(rst), .req(req), .mode(mode_e),
    .is_direct(is_direct), .is_mem(is_mem), .direct_pc(direct_pc), .rd_addr(rd_addr),
    .pc_in(pc_in), .mem_data(mem_data), .mem_valid(mem_valid),
    .pc_next(pc_next), .done(done), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .data_out(data_out), .busy(busy)
  );
endmodule

// File: rtl/pc_xfer_checker.sv
module pc_xfer_checker #(
  parameter int PC_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic [2:0]       mode,
  input logic [PC_W-1:0]  pc_in,
  input logic [PC_W-1:0]  imm,
  input logic             mem_valid,
  input logic             mem_rd,
  input logic [PC_W-1:0]  mem_addr,
  input logic [PC_W-1:0]  pc_next,
  input logic             done,
  input logic             busy
);
  // R9: a read strobe only follows an accepted request or a returned byte
  a_r9_rd_cause: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ($past(req) || $past(mem_valid)));

  // R9: the address holds while the unit waits for data
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_valid) |=> $stable(mem_addr));

  // R10: no completion while waiting without data, whatever req does
  a_r10_busy_no_done: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_valid) |=> !done);

  // R5: long jump loads the whole field in one cycle
  a_r5_long_target: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && mode == 3'd2) |=> (done && pc_next == $past(imm)));

  // R4: absolute jump keeps the segment bits
  a_r4_segment_kept: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && mode == 3'd1) |=> (done && pc_next[PC_W-1:PC_W-3] == $past(pc_in[PC_W-1:PC_W-3])));
endmodule

bind pc_xfer_unit pc_xfer_checker #(.PC_W(PC_W)) u_chk (.*);

// File: tb/pc_xfer_unit_bench.sv
module pc_xfer_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [14:0] pc_in = '0;
  logic [14:0] imm = '0;
  logic [7:0]  acc = '0;
  logic [7:0]  mem_data = '0;
  logic        mem_valid = 1'b0;
  logic        mem_rd;
  logic [14:0] mem_addr;
  logic [14:0] pc_next;
  logic        done;
  logic [7:0]  data_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_xfer_unit u_pc_xfer_unit (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .pc_in(pc_in), .imm(imm), .acc(acc),
    .mem_data(mem_data), .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .pc_next(pc_next), .done(done), .data_out(data_out)
  );

  function automatic logic [7:0] mbyte(input logic [14:0] a);
    return (a[7:0] * 8'd37) ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int          m_st = 0;
  logic [14:0] e_pc = '0, e_addr = '0, s_pc = '0;
  logic [7:0]  e_data = '0, s_hi = '0;
  logic        e_done = 0, e_rd = 0;
  int          s_mode = 0;
  string       tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; e_pc = '0; e_addr = '0; e_data = '0; e_done = 0; e_rd = 0; tag = "R1";
    end else begin
      e_done = 0; e_rd = 0;
      if (m_st == 0) begin
        if (req) begin
          int off;
          off = imm[5] ? int'(imm[5:0]) - 64 : int'(imm[5:0]);
          case (mode)
            3'd0: begin e_pc = 15'((int'(pc_in) + 1 + off) & 32'h7FFF); e_done = 1;
                  tag = (off == 0 || off == -32 || off == 31) ? "R3" : "R2"; end
            3'd1: begin e_pc = {pc_in[14:12], imm[11:0]}; e_done = 1; tag = "R4"; end
            3'd2: begin e_pc = imm; e_done = 1; tag = "R5"; end
            3'd3, 3'd4: begin e_addr = {pc_in[14:8], acc}; e_rd = 1; s_pc = pc_in;
                  s_mode = int'(mode); m_st = 1; tag = (mode == 3'd3) ? "R6" : "R7"; end
            3'd5: begin e_addr = imm; e_rd = 1; s_mode = 5; m_st = 1; tag = "R8"; end
            default: tag = "R10";
          endcase
        end else if (mem_valid) tag = "R10";
      end else if (m_st == 1) begin
        if (req) tag = "R10";
        if (mem_valid) begin
          if (s_mode == 5) begin s_hi = mem_data; e_addr = e_addr + 15'd1; e_rd = 1; m_st = 2; end
          else if (s_mode == 4) begin e_data = mem_data; e_pc = s_pc; e_done = 1; m_st = 0; end
          else begin e_pc = {s_pc[14:8], mem_data}; e_done = 1; m_st = 0; end
        end
      end else begin
        if (req) tag = "R10";
        if (mem_valid) begin e_pc = {s_hi[6:0], mem_data}; e_done = 1; m_st = 0; end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(tag, 32'(pc_next), 32'(e_pc));
      chk(tag, 32'(done), 32'(e_done));
      chk("R9", 32'(mem_rd), 32'(e_rd));
      chk("R9", 32'(mem_addr), 32'(e_addr));
      chk("R7", 32'(data_out), 32'(e_data));
    end
  end

  // Memory responder with per-read latency
  int          lat = 0;
  int          cnt = 0;
  bit          pend = 0;
  bit          stray = 0;
  logic [14:0] q_addr = '0;

  always @(negedge clk) begin
    mem_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin mem_valid = 1'b1; mem_data = mbyte(q_addr); pend = 0; end
      else cnt--;
    end else if (stray) begin
      mem_valid = 1'b1; mem_data = 8'hEE;
    end
    if (mem_rd) begin pend = 1; cnt = lat; q_addr = mem_addr; end
  end

  task automatic issue(input logic [2:0] m, input logic [14:0] p, input logic [14:0] i, input logic [7:0] a);
    @(negedge clk);
    req = 1'b1; mode = m; pc_in = p; imm = i; acc = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 32'(pc_next), 0);
    chk("R1", 32'(done), 0);
    chk("R1", 32'(mem_rd), 0);
    chk("R1", 32'(data_out), 0);
    rst = 1'b0;

    // R2 / R3 relative jumps
    issue(3'd0, 15'h0100, 15'h0005, 8'h00); settle();
    issue(3'd0, 15'h00F0, 15'h001F, 8'h00); settle();
    issue(3'd0, 15'h7FFE, 15'h0005, 8'h00); settle();
    issue(3'd0, 15'h0005, 15'h0020, 8'h00); settle();
    issue(3'd0, 15'h1234, 15'h0000, 8'h00); settle();
    issue(3'd0, 15'h2000, 15'h003F, 8'h00); settle();
    // R4 / R5
    issue(3'd1, 15'h5ABC, 15'h7123, 8'h00); settle();
    issue(3'd2, 15'h5ABC, 15'h6DEF, 8'h00); settle();
    // back-to-back direct requests
    @(negedge clk); req = 1; mode = 3'd2; imm = 15'h0AAA;
    @(negedge clk); mode = 3'd1; pc_in = 15'h7000; imm = 15'h0555;
    @(negedge clk); req = 0; settle();

    // R6 / R7 / R8 with several latencies
    for (int l = 0; l < 4; l++) begin
      lat = l;
      issue(3'd3, 15'h3A00 + 15'(l), 15'h0000, 8'h10 + 8'(l)); settle();
      issue(3'd4, 15'h4BCD, 15'h0000, 8'hF0 - 8'(l)); settle();
      issue(3'd5, 15'h0000, 15'h0200 + 15'(l * 3), 8'h00); settle();
    end
    lat = 1;
    issue(3'd5, 15'h0000, 15'h7FFF, 8'h00); settle();

    // R10: requests while busy
    lat = 4;
    issue(3'd5, 15'h0000, 15'h0345, 8'h00);
    issue(3'd2, 15'h0000, 15'h1111, 8'h00);
    issue(3'd3, 15'h0100, 15'h0000, 8'h22);
    settle(); settle();
    lat = 3;
    issue(3'd3, 15'h6600, 15'h0000, 8'h33);
    issue(3'd0, 15'h0010, 15'h0003, 8'h00);
    settle();
    // R10: reserved modes and stray valid
    lat = 0;
    issue(3'd6, 15'h1111, 15'h2222, 8'h44); settle();
    issue(3'd7, 15'h3333, 15'h4444, 8'h55); settle();
    @(negedge clk); stray = 1;
    repeat (3) @(negedge clk); stray = 0;
    settle();
    issue(3'd4, 15'h0E00, 15'h0000, 8'h01); settle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule